// File: doc/BRIEF.md
# Indirect Address/Data Register Bridge

This block is a bus-facing slave that reaches two internal register spaces, a top-level control space and a controller space. Each space is opened through its own channel. A channel has an address register, a data register and a control register. Software primes a channel by writing the target address to the address register twice in a row. It then moves data through the data register. A write takes a single data-register write. A read is pipelined: the first data-register read starts the internal fetch and returns whatever the channel held before, and the second read returns the fetched word.

Each internal space is reached through a request/acknowledge register port. The block holds the port request until the space acknowledges it. A strap input switches the block into a direct-mapped mode that bypasses the channels. In that mode top-space register N is a 32-bit word at byte offset 0x8000 + 4*N, and the controller space is byte-wide at the raw bus address. An access made through a channel that is not primed can raise a bus error, depending on an enable bit in that channel's control register.

Top module: `idx_reg_bridge`

## Requirements
- R1: In channel mode, bus_addr[4] selects the channel (0 = top space, 1 = controller space) and bus_addr[3:2] selects the register: 0 address, 1 data, 2 control. Any other offset, including 0xC, 0x1C and anything with bus_addr[15:5] nonzero, reads as zero with no error and has no effect.
- R2: An address-register write keeps only bus_wdata[15:0] as the channel's internal address. Reading the address register returns that value zero-extended, and internal accesses use it as the port address.
- R3: A channel is primed only by two address-register writes with no data-register access of that channel between them. A data access on an unprimed channel issues no internal port request.
- R4: On a primed channel, the first data-register read issues one internal read at the latched address and returns the value the channel held before. Later reads return the fetched word without an internal access, until the next address write on that channel.
- R5: On a primed channel, a single data-register write issues one internal write of the latched address and the full 32-bit word.
- R6: Control-register bit 15 enables errors, and the control register reads back only that bit. When the bit is set, a data access on an unprimed channel responds with bus_err high and zero read data. When the bit is clear, the access responds with zero, no error, and any write is dropped.
- R7: With map_direct high, a bus address with bit 15 set reaches the top space as 32-bit register (bus_addr[14:2]).
- R8: With map_direct high, a bus address with bit 15 clear reaches the controller space at the raw address. Only bus_wdata[7:0] is written, zero-extended, and read data is the low byte, zero-extended.
- R9: bus_ack is a one-cycle pulse. A response needing no internal access is acknowledged on the cycle after the request is accepted, and an internal access is acknowledged on the cycle after the port acknowledge. A port request is held until acknowledged, and at most one port request is active at a time.
- R10: After reset, bus_ack, bus_err and both port requests are low. Both channels are unprimed, their addresses are zero and their error enables are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_direct | input | 1 | 1 selects direct-mapped mode, 0 selects channel mode |
| bus_req | input | 1 | Bus request, accepted while the bridge is idle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Bus byte address |
| bus_wdata | input | 32 | Bus write data |
| bus_ack | output | 1 | One-cycle response strobe |
| bus_err | output | 1 | Error response, valid with bus_ack |
| bus_rdata | output | 32 | Read data, valid with bus_ack (zero for writes) |
| top_req | output | 1 | Top-space port request |
| top_we | output | 1 | Top-space port write enable |
| top_addr | output | 16 | Top-space port register address |
| top_wdata | output | 32 | Top-space port write data |
| top_rdata | input | 32 | Top-space port read data, valid with top_ack |
| top_ack | input | 1 | Top-space port acknowledge |
| core_req | output | 1 | Controller-space port request |
| core_we | output | 1 | Controller-space port write enable |
| core_addr | output | 16 | Controller-space port address |
| core_wdata | output | 32 | Controller-space port write data |
| core_rdata | input | 32 | Controller-space port read data, valid with core_ack |
| core_ack | input | 1 | Controller-space port acknowledge |

## Verification
Register reads, unprimed data accesses, already-fetched data reads and ignored offsets are due exactly one cycle after the accepting edge. Anything that goes through a port is due one cycle after that port's acknowledge, which with the bench's two-cycle memory model comes to four cycles after the accepting edge. The driver stores the due latency with each expected item. The monitor samples on the falling edge, measures the cycles from issue to bus_ack, and compares that count along with the data and the error bit. Access counters and the last address seen in the memory models show at the ports whether an internal access happened or was suppressed.

// File: rtl/idx_bridge_pkg.sv
package idx_bridge_pkg;

  localparam int unsigned BUS_AW   = 16;
  localparam int unsigned SPACES   = 2;
  localparam int unsigned CHAN_BIT = 4;
  localparam int unsigned REG_LSB  = 2;
  localparam int unsigned DIR_BIT  = 15;

  localparam logic SP_TOP  = 1'b0;
  localparam logic SP_CORE = 1'b1;

  typedef enum logic [1:0] {
    RG_ADDR = 2'd0,
    RG_DATA = 2'd1,
    RG_CTRL = 2'd2,
    RG_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } fsm_e;

  typedef enum logic [1:0] {
    PK_DIRECT = 2'd0,
    PK_FETCH  = 2'd1,
    PK_WRITE  = 2'd2
  } pend_e;

  // Register selected inside a channel window; anything above the two windows is a hole.
  function automatic reg_sel_e reg_of(input logic [BUS_AW-1:0] a);
    if (a[BUS_AW-1:CHAN_BIT+1] != '0) return RG_NONE;
    case (a[REG_LSB+1:REG_LSB])
      2'd0:    return RG_ADDR;
      2'd1:    return RG_DATA;
      2'd2:    return RG_CTRL;
      default: return RG_NONE;
    endcase
  endfunction

  function automatic logic chan_of(input logic [BUS_AW-1:0] a);
    return a[CHAN_BIT];
  endfunction

  function automatic logic direct_space(input logic [BUS_AW-1:0] a);
    return a[DIR_BIT] ? SP_TOP : SP_CORE;
  endfunction

  // Word index of a direct top-space access: strip the window bit and the byte lanes.
  function automatic logic [BUS_AW-1:0] top_word_index(input logic [BUS_AW-1:0] a);
    return BUS_AW'(a[DIR_BIT-1:REG_LSB]);
  endfunction

endpackage

// File: rtl/idx_chan_state.sv
module idx_chan_state #(
  parameter int unsigned DW = 32,
  parameter int unsigned IA = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_addr_wr,
  input  logic          ev_data,
  input  logic          ev_ctrl_wr,
  input  logic          ev_fetch_done,
  input  logic [IA-1:0] addr_in,
  input  logic          err_in,
  input  logic [DW-1:0] fetch_data,
  output logic [IA-1:0] addr_q,
  output logic          armed,
  output logic          fetched,
  output logic [DW-1:0] hold_q,
  output logic          err_en
);

  logic last_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      armed     <= 1'b0;
      fetched   <= 1'b0;
      hold_q    <= '0;
      err_en    <= 1'b0;
      last_addr <= 1'b0;
    end else begin
      if (ev_addr_wr) begin
        addr_q    <= addr_in;
        armed     <= last_addr;
        last_addr <= 1'b1;
        fetched   <= 1'b0;
      end else if (ev_data) begin
        last_addr <= 1'b0;
      end
      if (ev_fetch_done) begin
        hold_q  <= fetch_data;
        fetched <= 1'b1;
      end
      if (ev_ctrl_wr) err_en <= err_in;
    end
  end

endmodule

// File: rtl/idx_port_ctl.sv
module idx_port_ctl #(
  parameter int unsigned DW = 32,
  parameter int unsigned IA = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          l_we,
  input  logic [IA-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  input  logic          port_ack,
  output logic          port_req,
  output logic          port_we,
  output logic [IA-1:0] port_addr,
  output logic [DW-1:0] port_wdata,
  output logic          done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_req   <= 1'b0;
      port_we    <= 1'b0;
      port_addr  <= '0;
      port_wdata <= '0;
    end else if (launch) begin
      port_req   <= 1'b1;
      port_we    <= l_we;
      port_addr  <= l_addr;
      port_wdata <= l_wdata;
    end else if (port_req && port_ack) begin
      port_req <= 1'b0;
    end
  end

  assign done = port_req & port_ack;

endmodule

// File: rtl/idx_reg_bridge.sv
module idx_reg_bridge
  import idx_bridge_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned IA      = 16,
  parameter int unsigned ERR_BIT = 15,
  parameter int unsigned BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              map_direct,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic              bus_ack,
  output logic              bus_err,
  output logic [DW-1:0]     bus_rdata,
  output logic              top_req,
  output logic              top_we,
  output logic [IA-1:0]     top_addr,
  output logic [DW-1:0]     top_wdata,
  input  logic [DW-1:0]     top_rdata,
  input  logic              top_ack,
  output logic              core_req,
  output logic              core_we,
  output logic [IA-1:0]     core_addr,
  output logic [DW-1:0]     core_wdata,
  input  logic [DW-1:0]     core_rdata,
  input  logic              core_ack
);

  function automatic logic [DW-1:0] zext_byte(input logic [DW-1:0] v);
    return DW'(v[BYTE_W-1:0]);
  endfunction

  fsm_e  st;
  pend_e pend_kind;
  logic  pend_sp;
  logic  pend_we;
  logic  bus_ack_q, bus_err_q;
  logic [DW-1:0] bus_rdata_q;

  // Per-space state and port signals.
  logic [IA-1:0]     ch_addr  [SPACES];
  logic [DW-1:0]     ch_hold  [SPACES];
  logic [DW-1:0]     prd      [SPACES];
  logic [IA-1:0]     pa       [SPACES];
  logic [DW-1:0]     pwd      [SPACES];
  logic [SPACES-1:0] armed_v, fetched_v, err_en_v;
  logic [SPACES-1:0] ev_addr_wr, ev_data, ev_ctrl_wr, ev_fetch;
  logic [SPACES-1:0] launch_v, done_v, preq_v, pwe_v, pack_v;

  // Decode of the current request.
  logic     accept, ch, dsp, sel_sp, is_data, need_port;
  reg_sel_e rsel;
  logic [IA-1:0] l_addr;
  logic [DW-1:0] l_wdata;
  logic [DW-1:0] local_rd, resp_rd;
  logic          local_err, done_cur;

  // Named events, brought out for the checker.
  logic acc_launch, acc_local, acc_unarmed, acc_hit;

  assign accept  = bus_req && (st == ST_IDLE);
  assign rsel    = reg_of(bus_addr);
  assign ch      = chan_of(bus_addr);
  assign dsp     = direct_space(bus_addr);
  assign sel_sp  = map_direct ? dsp : ch;
  assign is_data = !map_direct && (rsel == RG_DATA);

  assign need_port   = map_direct ||
                       (is_data && armed_v[ch] && (bus_we || !fetched_v[ch]));
  assign acc_launch  = accept && need_port;
  assign acc_local   = accept && !need_port;
  assign acc_unarmed = accept && is_data && !armed_v[ch];
  assign acc_hit     = accept && is_data && armed_v[ch] && !bus_we && fetched_v[ch];

  assign prd[0]  = top_rdata;
  assign prd[1]  = core_rdata;
  assign pack_v  = {core_ack, top_ack};

  always_comb begin
    if (map_direct) begin
      if (dsp == SP_TOP) begin
        l_addr  = IA'(top_word_index(bus_addr));
        l_wdata = bus_wdata;
      end else begin
        l_addr  = IA'(bus_addr);
        l_wdata = zext_byte(bus_wdata);
      end
    end else begin
      l_addr  = ch_addr[ch];
      l_wdata = bus_wdata;
    end
  end

  always_comb begin
    for (int s = 0; s < SPACES; s++) begin
      launch_v[s]   = acc_launch && (sel_sp == 1'(s));
      ev_addr_wr[s] = accept && !map_direct && (rsel == RG_ADDR) && bus_we && (ch == 1'(s));
      ev_ctrl_wr[s] = accept && !map_direct && (rsel == RG_CTRL) && bus_we && (ch == 1'(s));
      ev_data[s]    = accept && is_data && (ch == 1'(s));
      ev_fetch[s]   = (st == ST_WAIT) && (pend_kind == PK_FETCH) &&
                      (pend_sp == 1'(s)) && done_v[s];
    end
  end

  for (genvar s = 0; s < SPACES; s++) begin : g_space
    idx_chan_state #(.DW(DW), .IA(IA)) chan_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .ev_addr_wr   (ev_addr_wr[s]),
      .ev_data      (ev_data[s]),
      .ev_ctrl_wr   (ev_ctrl_wr[s]),
      .ev_fetch_done(ev_fetch[s]),
      .addr_in      (bus_wdata[IA-1:0]),
      .err_in       (bus_wdata[ERR_BIT]),
      .fetch_data   (prd[s]),
      .addr_q       (ch_addr[s]),
      .armed        (armed_v[s]),
      .fetched      (fetched_v[s]),
      .hold_q       (ch_hold[s]),
      .err_en       (err_en_v[s])
    );

    idx_port_ctl #(.DW(DW), .IA(IA)) port_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch_v[s]),
      .l_we      (bus_we),
      .l_addr    (l_addr),
      .l_wdata   (l_wdata),
      .port_ack  (pack_v[s]),
      .port_req  (preq_v[s]),
      .port_we   (pwe_v[s]),
      .port_addr (pa[s]),
      .port_wdata(pwd[s]),
      .done      (done_v[s])
    );
  end

  assign top_req    = preq_v[0];
  assign top_we     = pwe_v[0];
  assign top_addr   = pa[0];
  assign top_wdata  = pwd[0];
  assign core_req   = preq_v[1];
  assign core_we    = pwe_v[1];
  assign core_addr  = pa[1];
  assign core_wdata = pwd[1];

  // Response for requests answered without a port access.
  always_comb begin
    local_rd = '0;
    if (!bus_we && !map_direct) begin
      case (rsel)
        RG_ADDR: local_rd = DW'(ch_addr[ch]);
        RG_CTRL: local_rd = DW'(err_en_v[ch]) << ERR_BIT;
        RG_DATA: local_rd = (armed_v[ch] && fetched_v[ch]) ? ch_hold[ch] : '0;
        default: local_rd = '0;
      endcase
    end
  end
  assign local_err = acc_unarmed && err_en_v[ch];

  // Response for a finished port access; a pipelined fetch returns the previous hold value.
  assign done_cur = (st == ST_WAIT) && done_v[pend_sp];
  always_comb begin
    resp_rd = '0;
    if (!pend_we) begin
      case (pend_kind)
        PK_FETCH:  resp_rd = ch_hold[pend_sp];
        PK_DIRECT: resp_rd = (pend_sp == SP_CORE) ? zext_byte(prd[pend_sp]) : prd[pend_sp];
        default:   resp_rd = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      pend_kind   <= PK_DIRECT;
      pend_sp     <= SP_TOP;
      pend_we     <= 1'b0;
      bus_ack_q   <= 1'b0;
      bus_err_q   <= 1'b0;
      bus_rdata_q <= '0;
    end else begin
      bus_ack_q <= 1'b0;
      bus_err_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (acc_launch) begin
            st        <= ST_WAIT;
            pend_sp   <= sel_sp;
            pend_we   <= bus_we;
            pend_kind <= map_direct ? PK_DIRECT : (bus_we ? PK_WRITE : PK_FETCH);
          end else if (acc_local) begin
            bus_ack_q   <= 1'b1;
            bus_err_q   <= local_err;
            bus_rdata_q <= local_err ? '0 : local_rd;
          end
        end
        default: begin
          if (done_cur) begin
            st          <= ST_IDLE;
            bus_ack_q   <= 1'b1;
            bus_rdata_q <= resp_rd;
          end
        end
      endcase
    end
  end

  assign bus_ack   = bus_ack_q;
  assign bus_err   = bus_err_q;
  assign bus_rdata = bus_rdata_q;

endmodule

// File: rtl/idx_reg_bridge_chk.sv
module idx_reg_bridge_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_ack,
  input logic          bus_err,
  input logic [DW-1:0] bus_rdata,
  input logic          top_req,
  input logic          top_ack,
  input logic          core_req,
  input logic          core_ack,
  input logic          acc_local,
  input logic          acc_unarmed,
  input logic          acc_hit
);

  // R9
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);

  // R9
  local_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_local |=> bus_ack);

  // R9
  top_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (top_req && !top_ack) |=> top_req);

  // R9
  core_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req && !core_ack) |=> core_req);

  // R9
  top_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (top_req && top_ack) |=> !top_req);

  // R9
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({top_req, core_req}));

  // R3
  unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_unarmed |=> (!top_req && !core_req));

  // R4
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |=> (!top_req && !core_req));

  // R6
  err_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_ack && bus_rdata == '0));

endmodule

bind idx_reg_bridge idx_reg_bridge_chk #(.DW(DW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_ack    (bus_ack),
  .bus_err    (bus_err),
  .bus_rdata  (bus_rdata),
  .top_req    (top_req),
  .top_ack    (top_ack),
  .core_req   (core_req),
  .core_ack   (core_ack),
  .acc_local  (acc_local),
  .acc_unarmed(acc_unarmed),
  .acc_hit    (acc_hit)
);

// File: tb/idx_reg_bridge_tb_top.sv
`timescale 1ns/1ps

module idx_reg_bridge_tb_mem #(
  parameter int unsigned LAT       = 2,
  parameter logic [31:0] INIT_BASE = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic [15:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        ack,
  output int          acc_cnt,
  output logic [15:0] last_addr
);
  logic [31:0] mem [64];
  int cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack       <= 1'b0;
      cnt       <= 0;
      acc_cnt   <= 0;
      last_addr <= '0;
      rdata     <= '0;
      for (int i = 0; i < 64; i++) mem[i] <= INIT_BASE + 32'(i);
    end else begin
      ack <= 1'b0;
      if (req && !ack) begin
        if (cnt == int'(LAT) - 1) begin
          ack       <= 1'b1;
          cnt       <= 0;
          acc_cnt   <= acc_cnt + 1;
          last_addr <= addr;
          rdata     <= mem[addr[5:0]];
          if (we) mem[addr[5:0]] <= wdata;
        end else begin
          cnt <= cnt + 1;
        end
      end
    end
  end
endmodule

module idx_reg_bridge_tb_top;

  localparam int MEM_LAT = 2;
  localparam int LOC     = 1;
  localparam int INT     = MEM_LAT + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic map_direct = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_ack, bus_err;
  logic [31:0] bus_rdata;
  logic top_req, top_we, top_ack, core_req, core_we, core_ack;
  logic [15:0] top_addr, core_addr, top_last, core_last;
  logic [31:0] top_wdata, top_rdata, core_wdata, core_rdata;
  int top_cnt, core_cnt;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    logic [31:0] rd;
    logic        err;
    int          lat;
    int          issue;
    string       tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  idx_reg_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .map_direct(map_direct),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
    .top_req(top_req), .top_we(top_we), .top_addr(top_addr), .top_wdata(top_wdata),
    .top_rdata(top_rdata), .top_ack(top_ack),
    .core_req(core_req), .core_we(core_we), .core_addr(core_addr), .core_wdata(core_wdata),
    .core_rdata(core_rdata), .core_ack(core_ack)
  );

  idx_reg_bridge_tb_mem #(.LAT(MEM_LAT), .INIT_BASE(32'hA000_0000)) top_mem_i (
    .clk(clk), .rst_n(rst_n), .req(top_req), .we(top_we), .addr(top_addr),
    .wdata(top_wdata), .rdata(top_rdata), .ack(top_ack),
    .acc_cnt(top_cnt), .last_addr(top_last)
  );

  idx_reg_bridge_tb_mem #(.LAT(MEM_LAT), .INIT_BASE(32'hC000_0000)) core_mem_i (
    .clk(clk), .rst_n(rst_n), .req(core_req), .we(core_we), .addr(core_addr),
    .wdata(core_wdata), .rdata(core_rdata), .ack(core_ack),
    .acc_cnt(core_cnt), .last_addr(core_last)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected item for every response.
  always @(negedge clk) begin
    if (rst_n && bus_ack) begin
      if (sb_q.size() == 0) begin
        n_chk++;
        n_fail++;
        $display("FAIL R9 unexpected ack act=1 exp=0");
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        chk({it.tag, " rdata"}, bus_rdata, it.rd);
        chk({it.tag, " err"}, 32'(bus_err), 32'(it.err));
        chk({it.tag, " R9 latency"}, 32'(cyc - it.issue), 32'(it.lat));
      end
    end
  end

  // Driver: queues the expectation, pulses the request, waits for the response.
  task automatic op(input logic we, input logic [15:0] a, input logic [31:0] wd,
                    input logic [31:0] exp_rd, input logic exp_err, input int lat,
                    input string tag);
    sb_item_t it;
    it.rd = exp_rd; it.err = exp_err; it.lat = lat; it.issue = cyc; it.tag = tag;
    sb_q.push_back(it);
    bus_we = we; bus_addr = a; bus_wdata = wd; bus_req = 1'b1;
    @(negedge clk);
    bus_req = 1'b0;
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R9 watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 bus_ack", 32'(bus_ack), 32'd0);
    chk("R10 bus_err", 32'(bus_err), 32'd0);
    chk("R10 port reqs", 32'({top_req, core_req}), 32'd0);
    op(1'b0, 16'h0000, 0, 32'h0, 1'b0, LOC, "R10 ch0 address");
    op(1'b0, 16'h0018, 0, 32'h0, 1'b0, LOC, "R10 ch1 control");

    // R2 low 16 bits kept; R3 a single address write does not prime
    op(1'b1, 16'h0000, 32'hABCD_0012, 32'h0, 1'b0, LOC, "R2 address write");
    op(1'b0, 16'h0000, 0, 32'h0000_0012, 1'b0, LOC, "R2 address readback");
    op(1'b0, 16'h0004, 0, 32'h0, 1'b0, LOC, "R3 read after one address write");
    op(1'b1, 16'h0000, 32'h12, 32'h0, 1'b0, LOC, "R3 address write after data");
    op(1'b0, 16'h0004, 0, 32'h0, 1'b0, LOC, "R3 pair broken by data access");
    chk("R3 no top access", 32'(top_cnt), 32'd0);

    // R4 pipelined read
    op(1'b1, 16'h0000, 32'h12, 32'h0, 1'b0, LOC, "R3 prime 1");
    op(1'b1, 16'h0000, 32'h12, 32'h0, 1'b0, LOC, "R3 prime 2");
    op(1'b0, 16'h0004, 0, 32'h0, 1'b0, INT, "R4 first read stale");
    chk("R4 one fetch", 32'(top_cnt), 32'd1);
    chk("R2 port address", 32'(top_last), 32'h12);
    op(1'b0, 16'h0004, 0, 32'hA000_0012, 1'b0, LOC, "R4 second read");
    op(1'b0, 16'h0004, 0, 32'hA000_0012, 1'b0, LOC, "R4 third read");
    chk("R4 no extra fetch", 32'(top_cnt), 32'd1);

    // R5 single write
    op(1'b1, 16'h0000, 32'h20, 32'h0, 1'b0, LOC, "R5 prime 1");
    op(1'b1, 16'h0000, 32'h20, 32'h0, 1'b0, LOC, "R5 prime 2");
    op(1'b1, 16'h0004, 32'h1234_5678, 32'h0, 1'b0, INT, "R5 data write");
    chk("R5 write reached port", 32'(top_cnt), 32'd2);
    chk("R5 write address", 32'(top_last), 32'h20);
    op(1'b0, 16'h0004, 0, 32'hA000_0012, 1'b0, INT, "R4 stale after new address");
    op(1'b0, 16'h0004, 0, 32'h1234_5678, 1'b0, LOC, "R5 written word");

    // R6 error enable
    op(1'b1, 16'h0018, 32'hFFFF_8000, 32'h0, 1'b0, LOC, "R6 ch1 control write");
    op(1'b0, 16'h0018, 0, 32'h0000_8000, 1'b0, LOC, "R6 ch1 control readback");
    op(1'b1, 16'h0008, 32'hFFFF_7FFF, 32'h0, 1'b0, LOC, "R6 ch0 control write");
    op(1'b0, 16'h0008, 0, 32'h0, 1'b0, LOC, "R6 ch0 control readback");
    op(1'b1, 16'h0010, 32'h5, 32'h0, 1'b0, LOC, "R6 ch1 single address");
    op(1'b1, 16'h0014, 32'h99, 32'h0, 1'b1, LOC, "R6 unprimed write error");
    op(1'b0, 16'h0014, 0, 32'h0, 1'b1, LOC, "R6 unprimed read error");
    chk("R6 no core access", 32'(core_cnt), 32'd0);
    op(1'b1, 16'h0010, 32'h5, 32'h0, 1'b0, LOC, "R5 ch1 prime 1");
    op(1'b1, 16'h0010, 32'h5, 32'h0, 1'b0, LOC, "R5 ch1 prime 2");
    op(1'b1, 16'h0014, 32'h55, 32'h0, 1'b0, INT, "R5 core write");
    op(1'b0, 16'h0014, 0, 32'h0, 1'b0, INT, "R4 core first read stale");
    op(1'b0, 16'h0014, 0, 32'h55, 1'b0, LOC, "R5 core readback");

    // R6 dropped write with errors disabled
    op(1'b1, 16'h0000, 32'h30, 32'h0, 1'b0, LOC, "R6 ch0 single address");
    op(1'b1, 16'h0004, 32'hDEAD, 32'h0, 1'b0, LOC, "R6 dropped write no error");
    chk("R6 dropped write no port access", 32'(top_cnt), 32'd3);
    op(1'b1, 16'h0000, 32'h30, 32'h0, 1'b0, LOC, "R6 prime 1");
    op(1'b1, 16'h0000, 32'h30, 32'h0, 1'b0, LOC, "R6 prime 2");
    op(1'b0, 16'h0004, 0, 32'h1234_5678, 1'b0, INT, "R4 stale hold");
    op(1'b0, 16'h0004, 0, 32'hA000_0030, 1'b0, LOC, "R6 dropped write left memory");

    // R1 holes and channel independence
    op(1'b0, 16'h000C, 0, 32'h0, 1'b0, LOC, "R1 hole read");
    op(1'b1, 16'h001C, 32'hFFFF_FFFF, 32'h0, 1'b0, LOC, "R1 hole write");
    op(1'b0, 16'h0040, 0, 32'h0, 1'b0, LOC, "R1 out of window");
    op(1'b0, 16'h0000, 0, 32'h30, 1'b0, LOC, "R1 ch0 address kept");
    op(1'b0, 16'h0010, 0, 32'h5, 1'b0, LOC, "R1 ch1 address kept");
    op(1'b0, 16'h0018, 0, 32'h8000, 1'b0, LOC, "R1 ch1 control kept");

    // R7 / R8 direct mode
    map_direct = 1'b1;
    op(1'b0, 16'h8048, 0, 32'hA000_0012, 1'b0, INT, "R7 direct top read");
    chk("R7 top word index", 32'(top_last), 32'h12);
    op(1'b1, 16'h801C, 32'hCAFE_F00D, 32'h0, 1'b0, INT, "R7 direct top write");
    chk("R7 top write index", 32'(top_last), 32'h7);
    op(1'b0, 16'h801C, 0, 32'hCAFE_F00D, 1'b0, INT, "R7 direct top readback");
    op(1'b1, 16'h0009, 32'hFFFF_FF3C, 32'h0, 1'b0, INT, "R8 direct core byte write");
    chk("R8 raw core address", 32'(core_last), 32'h9);
    op(1'b0, 16'h0009, 0, 32'h3C, 1'b0, INT, "R8 direct core readback");
    op(1'b0, 16'h0003, 0, 32'h03, 1'b0, INT, "R8 byte zero-extended");
    op(1'b0, 16'h0005, 0, 32'h55, 1'b0, INT, "R8 raw address bypasses channels");

    // back to channel mode: held value survives
    map_direct = 1'b0;
    op(1'b0, 16'h0004, 0, 32'hA000_0030, 1'b0, LOC, "R4 hold kept across mode switch");

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule